// File: doc/BRIEF.md
# Multi-Mode Cascadable Phase Counter

This block counts motion from incremental encoders. It has two channels, and each channel holds a 16-bit up/down count. A pair of external phase inputs drives each count. A per-channel mode field decides which input changes produce a count step and which direction that step takes. Three modes are supported:

- full-resolution quadrature, which counts on every edge of both inputs;
- pulse plus direction;
- half-resolution quadrature, which counts only on the second input.

Each channel also has a ceiling register. When clear-on-compare is turned on, the ceiling makes the count wrap as a modulo counter.

A shared control register can join the two channels into one 32-bit counter, with a 32-bit count and a 32-bit ceiling. The same register can also switch the second channel from inputs A/B to inputs C/D. All four phase inputs pass through a two-flop synchroniser before edge detection, so they may come straight from pins. Software reaches everything through a flat register port with single-cycle writes and combinational reads.

Register addresses (4-bit `addr`):

| Address | Register |
|---|---|
| 0 | channel 1 mode |
| 1 | channel 2 mode |
| 2 | channel 1 count (the 32-bit count when cascaded) |
| 3 | channel 2 count |
| 4 | channel 1 ceiling (the 32-bit ceiling when cascaded) |
| 5 | channel 2 ceiling |
| 6 | channel 1 status |
| 7 | channel 2 status |
| 8 | shared control |
| 9 | enable |

Mode registers hold the mode field in bits [3:0] and the clear-on-compare bit in bit 4.

Top module: `phc_top`

## Requirements
- R1: After reset, the following values hold. Both counts, both mode registers, the enable register (address 9), the shared control register (address 8) and both status registers (addresses 6, 7) read 0. Each ceiling reads 0xFFFF. With the cascade bit set, the ceiling at address 4 reads 0xFFFFFFFF.
- R2: Mode value 4 counts each single-input change. After a change of A, the count goes up if A differs from B and down otherwise. After a change of B, the count goes up if A equals B and down otherwise. If A and B change in the same clock, the count does not move.
- R3: Mode value 5 adds one step on each rising edge of A. The step is up when B is high and down when B is low. Falling edges of A and any change of B do not move the count.
- R4: Mode value 7 steps only on changes of B, using the same direction rule as R2. Changes of A do not move the count.
- R5: The count holds if the mode field holds any value other than 4, 5 or 7, or if the channel is not enabled.
- R6: Bit 7 of a channel's status register reads 1 after its latest step was upward and 0 after a downward step.
- R7: When mode bit 4 is 1, an up step from the ceiling value gives 0 and a down step from 0 gives the ceiling. When mode bit 4 is 0, the count wraps between all ones and 0 in both directions.
- R8: A write to a count register in the same clock as a count step stores the written value, and the step is lost.
- R9: When an enable bit goes from 0 to 1, that channel's mode register becomes 0x14 (mode 4 with clear-on-compare set).
- R10: With shared bit 0 set, the two channels form one 32-bit counter. Address 2 reads and writes the 32-bit count as a single word, and address 4 does the same for the 32-bit ceiling. The counter steps from the A/B inputs under channel 1's mode, and only while both enable bits are 1. An enable write then copies its bit 0 into both enable bits.
- R11: Shared bit 1 selects the inputs of channel 2: 0 selects A/B and 1 selects C/D. Channel 1 always counts from A/B.
- R12: A phase input change set up before clock edge k shows in the count after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_a | input | 1 | Phase input A (channel 1, and channel 2 when C/D is not selected) |
| ph_b | input | 1 | Phase input B |
| ph_c | input | 1 | Phase input C (channel 2 alternate pair) |
| ph_d | input | 1 | Phase input D |
| wr_en | input | 1 | Register write strobe, one write per clock |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
The properties assume three things about the inputs:

- software writes only the ten defined addresses;
- each level on a phase input lasts long enough to pass the synchroniser, so the step outputs reflect real input changes;
- the mode of a channel is not rewritten in the same clock as its enable rises.

The stimulus holds every phase-input state for four clocks and changes inputs only at falling clock edges. It issues register writes one at a time, and it places the write-versus-step collision on an exactly computed clock.

// File: rtl/phc_pkg.sv
package phc_pkg;
    localparam int REG_AW = 4;

    localparam logic [3:0] MODE_QUAD4    = 4'd4;
    localparam logic [3:0] MODE_PULSEDIR = 4'd5;
    localparam logic [3:0] MODE_QUAD2B   = 4'd7;

    localparam logic [REG_AW-1:0] A_MODE1  = 4'd0;
    localparam logic [REG_AW-1:0] A_MODE2  = 4'd1;
    localparam logic [REG_AW-1:0] A_COUNT1 = 4'd2;
    localparam logic [REG_AW-1:0] A_COUNT2 = 4'd3;
    localparam logic [REG_AW-1:0] A_CEIL1  = 4'd4;
    localparam logic [REG_AW-1:0] A_CEIL2  = 4'd5;
    localparam logic [REG_AW-1:0] A_STAT1  = 4'd6;
    localparam logic [REG_AW-1:0] A_STAT2  = 4'd7;
    localparam logic [REG_AW-1:0] A_SHARED = 4'd8;
    localparam logic [REG_AW-1:0] A_ENABLE = 4'd9;

    localparam int DIR_BIT = 7;
endpackage

// File: rtl/phc_sync.sv
module phc_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] cur,
    output logic [N-1:0] prv
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
        logic [N-1:0] last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = din;
        s_d.stab = s_q.meta;
        s_d.last = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur = s_q.stab;
    assign prv = s_q.last;
endmodule

// File: rtl/phc_step.sv
module phc_step
    import phc_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       a_cur,
    input  logic       b_cur,
    input  logic       a_prv,
    input  logic       b_prv,
    output logic       up,
    output logic       dn
);
    logic da, db, differ;

    always_comb begin
        da     = a_cur ^ a_prv;
        db     = b_cur ^ b_prv;
        differ = a_cur ^ b_cur;
        up     = 1'b0;
        dn     = 1'b0;
        case (mode)
            MODE_QUAD4: begin
                if (da && !db) begin
                    up = differ;
                    dn = !differ;
                end else if (db && !da) begin
                    up = !differ;
                    dn = differ;
                end
            end
            MODE_PULSEDIR: begin
                if (a_cur && !a_prv) begin
                    up = b_cur;
                    dn = !b_cur;
                end
            end
            MODE_QUAD2B: begin
                if (db) begin
                    up = !differ;
                    dn = differ;
                end
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/phc_top.sv
module phc_top
    import phc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ph_a,
    input  logic                 ph_b,
    input  logic                 ph_c,
    input  logic                 ph_d,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [2*CNT_W-1:0]   wdata,
    output logic [2*CNT_W-1:0]   rdata
);
    localparam int WIDE_W = 2 * CNT_W;
    localparam int NCH    = 2;
    localparam int NPH    = 4;
    localparam logic [WIDE_W-1:0] NARROW_TOP = {{CNT_W{1'b0}}, {CNT_W{1'b1}}};

    typedef struct packed {
        logic [NCH-1:0][CNT_W-1:0] cnt;
        logic [NCH-1:0][CNT_W-1:0] ceil;
        logic [NCH-1:0][3:0]       mode;
        logic [NCH-1:0]            clr;
        logic [NCH-1:0]            en;
        logic [NCH-1:0]            dir;
        logic                      cascade;
        logic                      pair_sel;
    } state_t;

    state_t s_d, s_q;

    logic [NPH-1:0] ph_cur, ph_prv;
    logic [NCH-1:0] step_up, step_dn;
    logic [NCH-1:0] ch_a_cur, ch_b_cur, ch_a_prv, ch_b_prv;
    logic [WIDE_W-1:0] wide_nv, narrow_nv;
    logic [NCH-1:0]    en_new;

    phc_sync #(.N(NPH)) i_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din ({ph_d, ph_c, ph_b, ph_a}),
        .cur (ph_cur),
        .prv (ph_prv)
    );

    // Channel 1 is tied to A/B; channel 2 follows the pair select.
    always_comb begin
        ch_a_cur[0] = ph_cur[0];
        ch_b_cur[0] = ph_cur[1];
        ch_a_prv[0] = ph_prv[0];
        ch_b_prv[0] = ph_prv[1];
        ch_a_cur[1] = s_q.pair_sel ? ph_cur[2] : ph_cur[0];
        ch_b_cur[1] = s_q.pair_sel ? ph_cur[3] : ph_cur[1];
        ch_a_prv[1] = s_q.pair_sel ? ph_prv[2] : ph_prv[0];
        ch_b_prv[1] = s_q.pair_sel ? ph_prv[3] : ph_prv[1];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_step
        phc_step i_step (
            .mode  (s_q.mode[g]),
            .a_cur (ch_a_cur[g]),
            .b_cur (ch_b_cur[g]),
            .a_prv (ch_a_prv[g]),
            .b_prv (ch_b_prv[g]),
            .up    (step_up[g]),
            .dn    (step_dn[g])
        );
    end

    // One step with modulo wrap: lim is the ceiling when clearing, else top.
    function automatic logic [WIDE_W-1:0] step_val(
        input logic [WIDE_W-1:0] v,
        input logic [WIDE_W-1:0] lim,
        input logic [WIDE_W-1:0] top,
        input logic              clr,
        input logic              up
    );
        logic [WIDE_W-1:0] wrap;
        wrap = clr ? lim : top;
        if (up) return (v == wrap) ? '0 : v + 1'b1;
        return (v == '0) ? wrap : v - 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        wide_nv   = '0;
        narrow_nv = '0;
        en_new    = s_q.en;

        // Counting
        if (s_q.cascade) begin
            if ((&s_q.en) && (step_up[0] || step_dn[0])) begin
                wide_nv = step_val({s_q.cnt[1], s_q.cnt[0]}, {s_q.ceil[1], s_q.ceil[0]},
                                   '1, s_q.clr[0], step_up[0]);
                s_d.cnt[0] = wide_nv[CNT_W-1:0];
                s_d.cnt[1] = wide_nv[WIDE_W-1:CNT_W];
                s_d.dir[0] = step_up[0];
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (s_q.en[i] && (step_up[i] || step_dn[i])) begin
                    narrow_nv = step_val({{CNT_W{1'b0}}, s_q.cnt[i]},
                                         {{CNT_W{1'b0}}, s_q.ceil[i]},
                                         NARROW_TOP, s_q.clr[i], step_up[i]);
                    s_d.cnt[i] = narrow_nv[CNT_W-1:0];
                    s_d.dir[i] = step_up[i];
                end
            end
        end

        // Register writes take priority over counting
        if (wr_en) begin
            case (addr)
                A_MODE1: begin
                    s_d.mode[0] = wdata[3:0];
                    s_d.clr[0]  = wdata[4];
                end
                A_MODE2: begin
                    s_d.mode[1] = wdata[3:0];
                    s_d.clr[1]  = wdata[4];
                end
                A_COUNT1: begin
                    s_d.cnt[0] = wdata[CNT_W-1:0];
                    if (s_q.cascade) s_d.cnt[1] = wdata[WIDE_W-1:CNT_W];
                end
                A_COUNT2: s_d.cnt[1] = wdata[CNT_W-1:0];
                A_CEIL1: begin
                    s_d.ceil[0] = wdata[CNT_W-1:0];
                    if (s_q.cascade) s_d.ceil[1] = wdata[WIDE_W-1:CNT_W];
                end
                A_CEIL2: s_d.ceil[1] = wdata[CNT_W-1:0];
                A_SHARED: begin
                    s_d.cascade  = wdata[0];
                    s_d.pair_sel = wdata[1];
                end
                A_ENABLE: begin
                    en_new = s_q.cascade ? {NCH{wdata[0]}} : wdata[NCH-1:0];
                    for (int i = 0; i < NCH; i++) begin
                        if (en_new[i] && !s_q.en[i]) begin
                            s_d.mode[i] = MODE_QUAD4;
                            s_d.clr[i]  = 1'b1;
                        end
                    end
                    s_d.en = en_new;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ceil <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE1:  rdata[4:0] = {s_q.clr[0], s_q.mode[0]};
            A_MODE2:  rdata[4:0] = {s_q.clr[1], s_q.mode[1]};
            A_COUNT1: rdata = s_q.cascade ? {s_q.cnt[1], s_q.cnt[0]}
                                          : {{CNT_W{1'b0}}, s_q.cnt[0]};
            A_COUNT2: rdata = {{CNT_W{1'b0}}, s_q.cnt[1]};
            A_CEIL1:  rdata = s_q.cascade ? {s_q.ceil[1], s_q.ceil[0]}
                                          : {{CNT_W{1'b0}}, s_q.ceil[0]};
            A_CEIL2:  rdata = {{CNT_W{1'b0}}, s_q.ceil[1]};
            A_STAT1:  rdata[DIR_BIT] = s_q.dir[0];
            A_STAT2:  rdata[DIR_BIT] = s_q.dir[1];
            A_SHARED: rdata[1:0] = {s_q.pair_sel, s_q.cascade};
            A_ENABLE: rdata[NCH-1:0] = s_q.en;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/phc_chk.sv
module phc_chk
    import phc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [REG_AW-1:0]   addr,
    input logic [2*CNT_W-1:0]  wdata,
    input logic [CNT_W-1:0]    cnt0,
    input logic [CNT_W-1:0]    cnt1,
    input logic [CNT_W-1:0]    ceil0,
    input logic [3:0]          mode0,
    input logic                clr0,
    input logic [1:0]          en,
    input logic                dir0,
    input logic                cascade,
    input logic                up0
);
    logic wr_cnt1, wr_cnt2;
    assign wr_cnt1 = wr_en && (addr == A_COUNT1);
    assign wr_cnt2 = wr_en && (addr == A_COUNT2);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt1 |=> cnt0 == $past(wdata[CNT_W-1:0]));

    assert_ceiling_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade && en[0] && clr0 && up0 && cnt0 == ceil0 && !wr_cnt1) |=> cnt0 == '0);

    assert_unsupported_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode0 != MODE_QUAD4 && mode0 != MODE_PULSEDIR && mode0 != MODE_QUAD2B && !wr_cnt1)
        |=> $stable(cnt0));

    assert_idle_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[1] && !wr_cnt2 && !(wr_cnt1 && cascade)) |=> $stable(cnt1));

    assert_enable_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en[0]) |-> (mode0 == MODE_QUAD4 && clr0));

    assert_dir_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up0 && (cascade ? (&en) : en[0])) |=> dir0);
endmodule

bind phc_top phc_chk #(.CNT_W(CNT_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt0    (s_q.cnt[0]),
    .cnt1    (s_q.cnt[1]),
    .ceil0   (s_q.ceil[0]),
    .mode0   (s_q.mode[0]),
    .clr0    (s_q.clr[0]),
    .en      (s_q.en),
    .dir0    (s_q.dir[0]),
    .cascade (s_q.cascade),
    .up0     (step_up[0])
);

// File: tb/test_phc_top.sv
module test_phc_top;
    import phc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ph_a = 1'b0, ph_b = 1'b0, ph_c = 1'b0, ph_d = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    phc_top i_phc_top (
        .clk (clk), .rst_n (rst_n),
        .ph_a (ph_a), .ph_b (ph_b), .ph_c (ph_c), .ph_d (ph_d),
        .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata)
    );

    // {mode[3:0], a, b, dir, 1'b0, count[15:0]}
    localparam int NROWS = 19;
    localparam logic [23:0] VEC [NROWS] = '{
        24'h4A0001, 24'h4E0002, 24'h460003, 24'h420004, 24'h440003,
        24'h4C0002, 24'h400002, 24'h540002, 24'h5E0003, 24'h520003,
        24'h580002, 24'h7E0003, 24'h760003, 24'h720004, 24'h7A0004,
        24'h7E0005, 24'h780004, 24'h000004, 24'h040004
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic drive_ab(input logic a, input logic b);
        @(negedge clk);
        ph_a = a; ph_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic drive_cd(input logic c, input logic d);
        @(negedge clk);
        ph_c = c; ph_d = d;
        repeat (4) @(negedge clk);
    endtask

    function automatic string mode_tag(input logic [3:0] m);
        case (m)
            4'd4:    return "R2 x4";
            4'd5:    return "R3 pulse/dir";
            4'd7:    return "R4 x2-B";
            default: return "R5 unsupported";
        endcase
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [23:0] row;
        logic [3:0]  cur_mode;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_COUNT1, v); chk("R1 count1", v, 32'h0);
        rd(A_CEIL1, v);  chk("R1 ceil1", v, 32'h0000FFFF);
        rd(A_CEIL2, v);  chk("R1 ceil2", v, 32'h0000FFFF);
        rd(A_MODE1, v);  chk("R1 mode1", v, 32'h0);
        rd(A_ENABLE, v); chk("R1 enable", v, 32'h0);
        rd(A_STAT1, v);  chk("R1 stat1", v, 32'h0);
        rd(A_SHARED, v); chk("R1 shared", v, 32'h0);
        wr(A_SHARED, 32'h1);
        rd(A_CEIL1, v);  chk("R1 ceil cascade", v, 32'hFFFFFFFF);
        wr(A_SHARED, 32'h0);

        // R5 disabled channel holds
        drive_ab(1'b1, 1'b0);
        rd(A_COUNT1, v); chk("R5 disabled holds", v, 32'h0);
        drive_ab(1'b0, 1'b0);

        // R9 enable initialises the mode
        wr(A_ENABLE, 32'h1);
        rd(A_MODE1, v);  chk("R9 mode1 init", v, 32'h14);
        rd(A_ENABLE, v); chk("R9 enable bit", v, 32'h1);

        // Vector table: R2, R3, R4, R5, R6
        cur_mode = 4'd4;
        for (int i = 0; i < NROWS; i++) begin
            row = VEC[i];
            if (row[23:20] != cur_mode) begin
                wr(A_MODE1, {27'h0, 1'b1, row[23:20]});
                cur_mode = row[23:20];
            end
            drive_ab(row[19], row[18]);
            rd(A_COUNT1, v); chk(mode_tag(row[23:20]), v, {16'h0, row[15:0]});
            rd(A_STAT1, v);  chk("R6 direction flag", {31'h0, v[7]}, {31'h0, row[17]});
        end
        rd(A_COUNT2, v); chk("R5 channel 2 disabled", v, 32'h0);

        // R7 ceiling wrap with clear on compare
        wr(A_MODE1, 32'h14);
        wr(A_CEIL1, 32'h5);
        wr(A_COUNT1, 32'h5);
        drive_ab(1'b0, 1'b0);
        rd(A_COUNT1, v); chk("R7 up from ceiling", v, 32'h0);
        drive_ab(1'b0, 1'b1);
        rd(A_COUNT1, v); chk("R7 down from zero", v, 32'h5);
        wr(A_MODE1, 32'h04);
        wr(A_COUNT1, 32'h5);
        drive_ab(1'b0, 1'b0);
        rd(A_COUNT1, v); chk("R7 no clear passes ceiling", v, 32'h6);
        wr(A_COUNT1, 32'h0);
        drive_ab(1'b0, 1'b1);
        rd(A_COUNT1, v); chk("R7 no clear wraps to ones", v, 32'h0000FFFF);

        // R12 latency: input change set before edge k, count moves at k+2
        wr(A_COUNT1, 32'h10);
        @(negedge clk); ph_a = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = A_COUNT1;
        #1 chk("R12 not yet after k+1", rdata, 32'h10);
        @(negedge clk);
        #1 chk("R12 moved after k+2", rdata, 32'h0F);

        // R8 write collides with a step
        @(negedge clk); ph_b = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = A_COUNT1; wdata = 32'h77;
        @(negedge clk); wr_en = 1'b0;
        #1 chk("R8 write wins", rdata, 32'h77);
        repeat (3) @(negedge clk);
        #1 chk("R8 step lost", rdata, 32'h77);

        // R11 pair select
        wr(A_SHARED, 32'h2);
        wr(A_ENABLE, 32'h3);
        rd(A_MODE2, v);  chk("R9 mode2 init", v, 32'h14);
        drive_cd(1'b1, 1'b0);
        rd(A_COUNT2, v); chk("R11 ch2 from C/D", v, 32'h1);
        rd(A_COUNT1, v); chk("R11 ch1 ignores C/D", v, 32'h77);
        drive_ab(1'b0, 1'b0);
        rd(A_COUNT1, v); chk("R11 ch1 from A/B", v, 32'h76);
        rd(A_COUNT2, v); chk("R11 ch2 ignores A/B", v, 32'h1);
        wr(A_SHARED, 32'h0);
        drive_ab(1'b1, 1'b0);
        rd(A_COUNT1, v); chk("R11 ch1 A/B again", v, 32'h77);
        rd(A_COUNT2, v); chk("R11 ch2 back on A/B", v, 32'h2);

        // R10 cascade
        wr(A_SHARED, 32'h1);
        wr(A_ENABLE, 32'h1);
        rd(A_ENABLE, v); chk("R10 enable both", v, 32'h3);
        wr(A_CEIL1, 32'hFFFFFFFF);
        wr(A_COUNT1, 32'h0000FFFF);
        wr(A_MODE1, 32'h14);
        drive_ab(1'b1, 1'b1);
        rd(A_COUNT1, v); chk("R10 carry into upper half", v, 32'h00010000);
        rd(A_COUNT2, v); chk("R10 upper half view", v, 32'h1);
        drive_ab(1'b1, 1'b0);
        rd(A_COUNT1, v); chk("R10 borrow from upper half", v, 32'h0000FFFF);
        wr(A_CEIL1, 32'h00012345);
        wr(A_COUNT1, 32'h0);
        drive_ab(1'b1, 1'b1);
        rd(A_COUNT1, v); chk("R10 up", v, 32'h1);
        drive_ab(1'b1, 1'b0);
        rd(A_COUNT1, v); chk("R10 down", v, 32'h0);
        drive_ab(1'b0, 1'b0);
        rd(A_COUNT1, v); chk("R10 wrap to 32-bit ceiling", v, 32'h00012345);
        wr(A_ENABLE, 32'h0);
        rd(A_ENABLE, v); chk("R10 disable both", v, 32'h0);
        drive_ab(1'b1, 1'b0);
        rd(A_COUNT1, v); chk("R5 cascade disabled holds", v, 32'h00012345);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule